// File: doc/BRIEF.md
# Serial Port Modem Status Generator

This block produces the 8-bit modem status value of a PC-style serial port. It takes its input from the 5-bit modem control value, which it holds itself. When the loopback control bit is clear, the status shows a fixed pattern: carrier detect and data-set-ready read as asserted, and clear-to-send and ring indicator read as deasserted. When loopback is set, four of the control outputs are fed back as the four status lines. Software reaches the block through a control write strobe and a status read strobe.

Each control write compares the old status lines with the new ones. Any change sets a sticky change indicator in the low nibble of the status. The ring line sets its indicator only on a falling edge. Reading the status returns the value as it stands and clears every indicator on the next clock. A pending flag shows whether any indicator is set, so the interrupt logic can act on it.

Top module: `mdm_status_unit`

## Requirements
- R1: After reset, `ctl_q` is 0x00, `sts` is 0xA0 and `delta_pend` is 0.
- R2: A write with `ctl_wr` stores `ctl_wdata[4:0]` into `ctl_q` on the next clock. Bits 7:5 of the write data are dropped.
- R3: When `ctl_q[4]` (loopback) is 0, status bits 7..4 read 1,0,1,0 (carrier detect 1, ring 0, data-set-ready 1, clear-to-send 0), whatever the other control bits hold.
- R4: When `ctl_q[4]` is 1, the status lines follow the control bits: bit4 (clear-to-send) = `ctl_q[1]`, bit5 (data-set-ready) = `ctl_q[0]`, bit6 (ring) = `ctl_q[2]`, bit7 (carrier detect) = `ctl_q[3]`.
- R5: On a control write, a change in clear-to-send, data-set-ready or carrier detect between the old and new status sets status bit 0, bit 1 or bit 3 respectively.
- R6: Status bit 2 (trailing ring edge) is set only when the ring line goes from 1 to 0 on a write. A 0-to-1 change leaves it unchanged.
- R7: Change indicators are sticky. A control write replaces bits 7:4 and only ORs into bits 3:0.
- R8: While `sts_rd` is high, `sts` shows the current value. On the next clock, bits 3:0 are cleared and bits 7:4 are kept.
- R9: When a read and a write fall in the same cycle, the indicators that existed before that cycle are cleared, and those raised by that write are kept.
- R10: `delta_pend` is 1 exactly when any of status bits 3:0 is 1.
- R11: In a cycle with neither strobe, `sts` and `ctl_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Modem control write strobe |
| ctl_wdata | input | 8 | Modem control write data |
| sts_rd | input | 1 | Modem status read strobe |
| ctl_q | output | 5 | Held modem control value |
| sts | output | 8 | Modem status value |
| delta_pend | output | 1 | Any change indicator set |

## Verification
The hardest case to reach is a read and a control write in the same cycle. Here the old indicators must clear while the new ones survive. The bench first raises a clear-to-send indicator in loopback. In the next cycle it reads and drops the ring line together, then expects only the trailing ring indicator to remain. Falling ring edges also need loopback to be entered with the ring output already high, so the bench arranges that state before it releases the ring output.

// File: rtl/mdm_status_unit.sv
module mdm_status_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       sts_rd,
  output logic [4:0] ctl_q,
  output logic [7:0] sts,
  output logic       delta_pend
);
  logic [4:0] ctl_n;
  logic [3:0] lines_old, lines_new, chg;
  logic [3:0] kept;

  assign ctl_n = ctl_wdata[4:0];

  // lines order: {dcd, ri, dsr, cts}
  assign lines_old = sts[7:4];
  assign lines_new = ctl_n[4] ? {ctl_n[3], ctl_n[2], ctl_n[0], ctl_n[1]} : 4'b1010;

  assign chg[0] = lines_old[0] ^ lines_new[0];
  assign chg[1] = lines_old[1] ^ lines_new[1];
  assign chg[2] = lines_old[2] & ~lines_new[2];
  assign chg[3] = lines_old[3] ^ lines_new[3];

  assign kept = sts_rd ? 4'b0000 : sts[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 5'd0;
      sts   <= 8'hA0;
    end else if (ctl_wr) begin
      ctl_q <= ctl_n;
      sts   <= {lines_new, kept | chg};
    end else if (sts_rd) begin
      sts[3:0] <= 4'b0000;
    end
  end

  assign delta_pend = |sts[3:0];
endmodule

module mdm_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic       sts_rd,
  input logic [4:0] ctl_q,
  input logic [7:0] sts,
  input logic       delta_pend
);
  // R2
  ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_q == $past(ctl_wdata[4:0]));

  // R3
  normal_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[4]) |=> sts[7:4] == 4'b1010);

  // R4
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[4]) |=> (sts[4] == $past(ctl_wdata[1])) && (sts[5] == $past(ctl_wdata[0]))
                              && (sts[6] == $past(ctl_wdata[2])) && (sts[7] == $past(ctl_wdata[3])));

  // R6
  ri_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !sts[6] && !sts[2] && !sts_rd) |=> !sts[2]);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !sts_rd) |=> (sts[3:0] & $past(sts[3:0])) == $past(sts[3:0]));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !ctl_wr) |=> (sts[3:0] == 4'b0000) && (sts[7:4] == $past(sts[7:4])));

  // R10
  pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delta_pend == (sts[3:0] != 4'b0000));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && !sts_rd) |=> $stable(sts) && $stable(ctl_q));
endmodule

bind mdm_status_unit mdm_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .sts_rd(sts_rd), .ctl_q(ctl_q), .sts(sts), .delta_pend(delta_pend)
);

// File: tb/mdm_status_unit_tb.sv
module mdm_status_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       sts_rd = 1'b0;
  logic [4:0] ctl_q;
  logic [7:0] sts;
  logic       delta_pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mdm_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sts_rd(sts_rd), .ctl_q(ctl_q), .sts(sts), .delta_pend(delta_pend)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_sts(input string req, input logic [7:0] exp);
    chk(req, sts, exp);
    chk({req, "/R10"}, {7'd0, delta_pend}, {7'd0, |exp[3:0]});
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_wdata = d; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] exp_now);
    sts_rd = 1'b1;
    #0;
    chk_sts({req, "/R8 read value"}, exp_now);
    @(negedge clk);
    sts_rd = 1'b0;
    chk_sts({req, "/R8 after read"}, {exp_now[7:4], 4'h0});
  endtask

  task automatic t_reset;
    chk("R1 ctl", {3'd0, ctl_q}, 8'h00);
    chk_sts("R1 sts", 8'hA0);
  endtask

  task automatic t_normal;
    wr(8'h0F);
    chk("R2 ctl", {3'd0, ctl_q}, 8'h0F);
    chk_sts("R3 pattern", 8'hA0);
    wr(8'hEF);
    chk("R2 upper dropped", {3'd0, ctl_q}, 8'h0F);
    chk_sts("R3 pattern", 8'hA0);
    @(negedge clk);
    chk_sts("R11 idle", 8'hA0);
  endtask

  task automatic t_enter_loop;
    wr(8'h10);
    chk_sts("R4 R5 loop all low", 8'h0A);
    rd_check("R5", 8'h0A);
  endtask

  task automatic t_all_high;
    wr(8'h1F);
    chk_sts("R4 R5 R6 all high", 8'hFB);
    rd_check("R4", 8'hFB);
  endtask

  task automatic t_ring_fall;
    wr(8'h1B);
    chk_sts("R6 ring fall", 8'hB4);
    rd_check("R6", 8'hB4);
  endtask

  task automatic t_sticky;
    wr(8'h19);
    chk_sts("R7 first change", 8'hA1);
    wr(8'h11);
    chk_sts("R7 sticky", 8'h29);
    rd_check("R7", 8'h29);
    wr(8'h12);
    chk_sts("R4 R5 rts only", 8'h13);
    rd_check("R4", 8'h13);
  endtask

  task automatic t_collide;
    wr(8'h14);
    chk_sts("R6 ring rise no teri", 8'h41);
    ctl_wdata = 8'h10; ctl_wr = 1'b1; sts_rd = 1'b1;
    #0;
    chk_sts("R9 read value", 8'h41);
    @(negedge clk);
    ctl_wr = 1'b0; sts_rd = 1'b0;
    chk_sts("R9 new kept old cleared", 8'h04);
    wr(8'h00);
    chk_sts("R3 R7 leave loop", 8'hAE);
    rd_check("R3", 8'hAE);
    @(negedge clk);
    chk_sts("R11 hold", 8'hA0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_enter_loop();
    t_all_high();
    t_ring_fall();
    t_sticky();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule